// File: doc/BRIEF.md
# Bursting memory-mapped request rule checker

This block sits beside a bursting memory-mapped slave port that feeds a memory-to-packet bridge. It does not drive the port. It watches the select, read and write strobes, the address, the write data, the byte enables, the burst count and the bridge's stall signal. It flags every request that breaks the port's rules. The data width is a parameter and may be 64 or 128 bits. From that width it derives the burst count field width: 7 bits for 64-bit data and 6 bits for 128-bit data. It also derives the largest legal burst, which is 512 bytes divided by the beat size.

For each write burst the checker keeps a count of the beats still to come. This lets it tell first, middle and last beats apart, and apply the byte-enable rule that suits each position. It checks three things:
- the shape of the byte-enable pattern;
- the burst length;
- whether a stalled request stays unchanged.

Each violation sets a sticky flag for its kind. A 3-bit code keeps the kind of the first violation seen. A synchronous clear pulse empties both the flags and the code.

Top module: `avmm_burst_checker`

## Requirements
- R1: After reset, `err_flags` is 0 and `err_code` is 0.
- R2: An accepted read command, or the first accepted beat of a write burst, whose burst count is 0 or larger than 512/(DATA_W/8) sets `err_flags[2]`. The code for this violation is 3. A beat is accepted when chip select is high, read or write is high, and waitrequest is low.
- R3: An accepted write beat that is neither the first nor the last beat of its burst must have all byte enables set. Otherwise `err_flags[1]` is set, with code 2. The first and last beats may carry partial enables. The only beat of a one-beat burst counts as both first and last.
- R4: At DATA_W=128, every accepted write beat and every accepted read command needs a byte-enable pattern that meets three conditions. Each 4-bit group must be all ones or all zeros. At least one group must be enabled. The enabled groups must form one contiguous run. Otherwise `err_flags[0]` is set, with code 1. An example of a violation is 16'hF0F0, 16'h0000 or 16'h1F00. At DATA_W=64 there is no shape rule.
- R5: Take a write that was stalled in the previous cycle (strobe active while waitrequest was high). If in this cycle its select or write strobe drops, read rises, or the address, byte enables, burst count or write data change, `err_flags[3]` is set, with code 4. The same applies to a stalled read whose write strobe rises or whose address, byte enables or burst count change.
- R6: If a read was stalled in the previous cycle and in this cycle chip select or read is low, `err_flags[4]` is set, with code 5.
- R7: A read is one command whatever its burst count. It opens no write burst. The next accepted write is therefore taken as a first beat.
- R8: Flags are sticky until `clr_i` is sampled high. That clock edge leaves the flags and the code at 0, even if a violation occurs in the same cycle.
- R9: `err_code` holds the code of the first violation since reset or clear. When several violations occur in the same cycle, the lowest code wins. Later violations only add flag bits.
- R10: A write burst ends after exactly the number of beats given on its first beat. The burst count on later beats is ignored. The next accepted write after the last beat starts a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the flags and code |
| cs_i | input | 1 | Port chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Write data |
| be_i | input | DATA_W/8 | Byte enables |
| bcnt_i | input | 7 (DATA_W=64) or 6 (DATA_W=128) | Burst count in beats |
| waitreq_i | input | 1 | Stall from the bridge |
| err_flags | output | 5 | Sticky flags: bit0 shape, bit1 middle beat, bit2 count, bit3 unstable, bit4 read withdrawn |
| err_code | output | 3 | Code of the first violation (0 means none) |

## Verification
The assertions assume two things. Read and write are never high together, and a read does not arrive while a write burst is still open. The bench's stimulus respects both: it issues reads only between bursts and never raises both strobes. The behavioural model in the bench takes every shape, count, position and stall-stability rule as given above. Because the bench drives deliberate violations for each rule, the assertions also see sticky flags build up across several kinds, and clears land both on idle cycles and in the same cycle as a violation.

// File: rtl/avmm_burst_checker.sv
module avmm_burst_checker #(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 32,
  localparam int BE_W = DATA_W / 8,
  localparam int BC_W = (DATA_W == 128) ? 6 : 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [BC_W-1:0]   bcnt_i,
  input  logic              waitreq_i,
  output logic [4:0]        err_flags,
  output logic [2:0]        err_code
);
  localparam int MAX_BC = 512 / BE_W;

  logic act, is_wr, is_rd, acc, stall;
  assign is_wr = cs_i & wr_i;
  assign is_rd = cs_i & rd_i & ~wr_i;
  assign act   = cs_i & (rd_i | wr_i);
  assign acc   = act & ~waitreq_i;
  assign stall = act & waitreq_i;

  logic [BC_W-1:0] rem_q;
  logic in_burst, first_beat, last_beat, bc_bad, cmd_start;
  assign in_burst   = rem_q != '0;
  assign first_beat = ~in_burst;
  assign last_beat  = in_burst ? (rem_q == BC_W'(1)) : (bcnt_i == BC_W'(1));
  assign bc_bad     = (bcnt_i == '0) || (bcnt_i > BC_W'(MAX_BC));
  assign cmd_start  = acc & (is_rd | (is_wr & first_beat));

  logic shape_ok;
  generate
    if (DATA_W == 128) begin : g_shape128
      logic [3:0] dmask;
      logic [3:0] uni;
      logic [4:0] fill;
      for (genvar i = 0; i < 4; i++) begin : g_dw
        assign dmask[i] = be_i[4*i];
        assign uni[i]   = (be_i[4*i +: 4] == 4'hF) || (be_i[4*i +: 4] == 4'h0);
      end
      assign fill = ({1'b0, dmask} | ({1'b0, dmask} - 5'd1)) + 5'd1;
      assign shape_ok = (&uni) && (dmask != 4'd0) && ((fill & {1'b0, dmask}) == 5'd0);
    end else begin : g_shape64
      assign shape_ok = 1'b1;
    end
  endgenerate

  logic stall_q, was_rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic [BE_W-1:0]   be_q;
  logic [BC_W-1:0]   bc_q;

  logic v_shape, v_mid, v_count, v_chg, v_drop;
  logic same_cmd;
  assign same_cmd = (addr_i == addr_q) && (be_i == be_q) && (bcnt_i == bc_q);
  assign v_shape = acc & (is_wr | is_rd) & ~shape_ok;
  assign v_mid   = acc & is_wr & ~first_beat & ~last_beat & (be_i != '1);
  assign v_count = cmd_start & bc_bad;
  assign v_drop  = stall_q & was_rd_q & ~(cs_i & rd_i);
  assign v_chg   = stall_q & ~v_drop &
                   (was_rd_q ? (wr_i | ~same_cmd)
                             : (~is_wr | rd_i | ~same_cmd | (wdata_i != wd_q)));

  logic [4:0] viol;
  logic [2:0] first_code;
  assign viol = {v_drop, v_chg, v_count, v_mid, v_shape};

  always_comb begin
    first_code = 3'd0;
    for (int k = 4; k >= 0; k--)
      if (viol[k]) first_code = 3'(k + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      stall_q  <= 1'b0;
      was_rd_q <= 1'b0;
      addr_q   <= '0;
      wd_q     <= '0;
      be_q     <= '0;
      bc_q     <= '0;
    end else begin
      if (acc & is_wr) begin
        if (first_beat) rem_q <= bc_bad ? '0 : bcnt_i - BC_W'(1);
        else            rem_q <= rem_q - BC_W'(1);
      end
      stall_q <= stall;
      if (stall) begin
        was_rd_q <= is_rd;
        addr_q   <= addr_i;
        wd_q     <= wdata_i;
        be_q     <= be_i;
        bc_q     <= bcnt_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flags <= '0;
      err_code  <= '0;
    end else if (clr_i) begin
      err_flags <= '0;
      err_code  <= '0;
    end else begin
      err_flags <= err_flags | viol;
      if (err_code == 3'd0) err_code <= first_code;
    end
  end

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (err_flags == 5'd0 && err_code == 3'd0));

  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && err_code != 3'd0) |=> err_code == $past(err_code));

  p_code_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 3'd0) |-> (((err_flags >> (err_code - 3'd1)) & 5'd1) == 5'd1));

  p_flags_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != 5'd0) |-> (err_code != 3'd0));

  p_rem_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= BC_W'(MAX_BC - 1));

  p_code_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_code <= 3'd5);
endmodule

// File: tb/avmm_burst_checker_bench.sv
module avmm_burst_checker_bench;
  localparam int CLK_P  = 10;
  localparam int DW     = 128;
  localparam int AW     = 32;
  localparam int BEW    = DW / 8;
  localparam int BCW    = 6;
  localparam int MAXB   = 512 / BEW;

  logic clk = 0, rst_n = 0, clr = 0;
  logic cs = 0, rd = 0, wr = 0, wt = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd = '0;
  logic [BEW-1:0] be = '0;
  logic [BCW-1:0] bc = '0;
  logic [4:0] flags;
  logic [2:0] code;

  int checks = 0, fails = 0;
  bit done = 0;

  avmm_burst_checker #(.DATA_W(DW), .ADDR_W(AW)) u_avmm_burst_checker (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wd), .be_i(be), .bcnt_i(bc), .waitreq_i(wt),
    .err_flags(flags), .err_code(code));

  always #(CLK_P/2) clk = ~clk;

  int m_rem = 0, m_flags = 0, m_code = 0;
  bit m_stall = 0, m_wasrd = 0;
  logic [AW-1:0] m_a; logic [DW-1:0] m_d; logic [BEW-1:0] m_b; logic [BCW-1:0] m_c;

  function automatic bit shape_good(logic [BEW-1:0] b);
    int lo = -1, hi = -1, n = 0;
    for (int i = 0; i < 4; i++) begin
      if (b[4*i +: 4] != 4'hF && b[4*i +: 4] != 4'h0) return 0;
      if (b[4*i]) begin if (lo < 0) lo = i; hi = i; n++; end
    end
    return (n > 0) && (hi - lo + 1 == n);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 0; m_flags = 0; m_code = 0; m_stall = 0; m_wasrd = 0;
    end else begin
      automatic int v = 0;
      automatic bit w  = cs && wr;
      automatic bit r  = cs && rd && !wr;
      automatic bit ok = cs && (rd || wr) && !wt;
      automatic bit badc = (bc == 0) || (int'(bc) > MAXB);
      if (ok && (w || r) && !shape_good(be)) v |= 1;
      if (ok && w && m_rem > 1 && be != '1) v |= 2;
      if (ok && (r || (w && m_rem == 0)) && badc) v |= 4;
      if (m_stall && m_wasrd && !(cs && rd)) v |= 16;
      else if (m_stall) begin
        automatic bit diff = (addr != m_a) || (be != m_b) || (bc != m_c);
        if (m_wasrd ? (wr || diff) : (!w || rd || diff || wd != m_d)) v |= 8;
      end
      if (ok && w) begin
        if (m_rem == 0) m_rem = badc ? 0 : int'(bc) - 1;
        else m_rem--;
      end
      m_stall = cs && (rd || wr) && wt;
      if (m_stall) begin m_wasrd = r; m_a = addr; m_d = wd; m_b = be; m_c = bc; end
      if (clr) begin m_flags = 0; m_code = 0; end
      else begin
        if (m_code == 0)
          for (int k = 4; k >= 0; k--) if (v[k]) m_code = k + 1;
        m_flags |= v;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (flags !== 5'(m_flags)) begin
      fails++; $display("FAIL R8 model flags actual=%b expected=%b", flags, 5'(m_flags));
    end
    checks++;
    if (code !== 3'(m_code)) begin
      fails++; $display("FAIL R9 model code actual=%0d expected=%0d", code, m_code);
    end
  end

  task automatic chk(string tag, logic [4:0] ef, logic [2:0] ec);
    checks++;
    if (flags !== ef || code !== ec) begin
      fails++;
      $display("FAIL %s flags=%b code=%0d expected flags=%b code=%0d", tag, flags, code, ef, ec);
    end
  endtask

  task automatic cyc(bit c, bit r, bit w, logic [AW-1:0] a, logic [BEW-1:0] b,
                     logic [BCW-1:0] n, logic [DW-1:0] d, bit s, bit cl);
    cs = c; rd = r; wr = w; addr = a; be = b; bc = n; wd = d; wt = s; clr = cl;
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0, 0, 0, '0, '0, '0, '0, 0, 0); endtask
  task automatic clear(); cyc(0, 0, 0, '0, '0, '0, '0, 0, 1); idle(); endtask
  task automatic wbeat(logic [BEW-1:0] b, logic [BCW-1:0] n);
    cyc(1, 0, 1, 32'h100, b, n, {4{32'hA5A5_0000}}, 0, 0);
  endtask

  initial begin
    #(CLK_P * 3);
    @(negedge clk); rst_n = 1;
    idle();
    chk("R1 reset", 5'b0, 3'd0);

    wbeat(16'hF000, 6'd3); wbeat(16'hFFFF, 6'd0); wbeat(16'h000F, 6'd0); idle();
    chk("R3 partial first/last ok", 5'b0, 3'd0);
    wbeat(16'h0F00, 6'd1); idle();
    chk("R3 single beat partial ok", 5'b0, 3'd0);
    wbeat(16'hFFFF, 6'd3); wbeat(16'h0FFF, 6'd3); wbeat(16'hFFFF, 6'd3); idle();
    chk("R3 partial middle beat", 5'b00010, 3'd2);
    clear();

    wbeat(16'hFFFF, 6'd0); idle();
    chk("R2 zero count", 5'b00100, 3'd3);
    clear();
    for (int i = 0; i < MAXB; i++) wbeat(16'hFFFF, 6'(MAXB));
    idle();
    chk("R2 max burst ok", 5'b0, 3'd0);
    wbeat(16'hFFFF, 6'(MAXB + 1)); idle();
    chk("R2 count over limit", 5'b00100, 3'd3);
    clear();

    wbeat(16'hF0F0, 6'd1); idle();
    chk("R4 gap pattern", 5'b00001, 3'd1);
    clear();
    wbeat(16'h1F00, 6'd1); idle();
    chk("R4 partial dword", 5'b00001, 3'd1);
    clear();
    cyc(1, 1, 0, 32'h40, 16'h0000, 6'd4, '0, 0, 0); idle();
    chk("R4 empty enable on read", 5'b00001, 3'd1);
    clear();

    cyc(1, 0, 1, 32'h200, 16'hFFFF, 6'd1, 128'h1, 1, 0);
    cyc(1, 0, 1, 32'h200, 16'hFFFF, 6'd1, 128'h1, 1, 0);
    cyc(1, 0, 1, 32'h200, 16'hFFFF, 6'd1, 128'h1, 0, 0); idle();
    chk("R5 held write ok", 5'b0, 3'd0);
    cyc(1, 0, 1, 32'h200, 16'hFFFF, 6'd1, 128'h1, 1, 0);
    cyc(1, 0, 1, 32'h208, 16'hFFFF, 6'd1, 128'h1, 0, 0); idle();
    chk("R5 address changed in stall", 5'b01000, 3'd4);
    clear();
    cyc(1, 0, 1, 32'h200, 16'hFFFF, 6'd1, 128'h1, 1, 0);
    cyc(1, 0, 1, 32'h200, 16'hFFFF, 6'd1, 128'h2, 0, 0); idle();
    chk("R5 data changed in stall", 5'b01000, 3'd4);
    clear();

    cyc(1, 1, 0, 32'h300, 16'hFFFF, 6'd8, '0, 1, 0);
    cyc(0, 0, 0, 32'h300, 16'hFFFF, 6'd8, '0, 1, 0); idle();
    chk("R6 read dropped", 5'b10000, 3'd5);
    clear();

    cyc(1, 1, 0, 32'h300, 16'hFFFF, 6'd8, '0, 0, 0);
    wbeat(16'h000F, 6'd1); idle();
    chk("R7 read opens no burst", 5'b0, 3'd0);

    wbeat(16'hFFFF, 6'd2); wbeat(16'h00FF, 6'd0); idle();
    chk("R10 later count ignored", 5'b0, 3'd0);
    wbeat(16'hFFFF, 6'd0); idle();
    chk("R10 new burst after last", 5'b00100, 3'd3);

    idle(); idle();
    chk("R8 flag sticky", 5'b00100, 3'd3);
    cyc(1, 0, 1, 32'h0, 16'hF0F0, 6'd0, '0, 0, 1); idle();
    chk("R8 clear beats same-cycle violation", 5'b0, 3'd0);

    wbeat(16'hF0F0, 6'd0); idle();
    chk("R9 lowest code wins", 5'b00101, 3'd1);
    cyc(1, 1, 0, 32'h10, 16'hFFFF, 6'd1, '0, 1, 0);
    cyc(0, 0, 0, 32'h10, 16'hFFFF, 6'd1, '0, 0, 0); idle();
    chk("R9 first code kept", 5'b10101, 3'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule